// File: doc/BRIEF.md
# Operand Address Resolver

This block sits between instruction decode and execute in a 16-bit microcontroller core. It receives an instruction word and works out where its operands live. Each operand comes out as one of three things: a register select, an effective memory address, or a literal value. A literal value is either a generated constant or an immediate taken from the instruction stream. Extension words that follow the instruction are fetched through a word-wide memory read port at the program counter. Every extension word consumed writes the program counter forward. The auto-increment addressing form writes the incremented register back, and a byte-wide register destination has its upper byte cleared through the same register write port.

A pulse on `start` loads the instruction and the program counter value that points at the first word after the opcode. A short sequence then runs. It resolves the source, fetches the source extension word when one is needed, resolves the destination, fetches its extension word when one is needed, and finally raises `done` for one cycle. The operand outputs stay unchanged after `done` until the next start. Registers R2 and R3 serve as a constant generator when used as sources. Register R0 used as a source gives relative (symbolic) and immediate operands.

Top module: `opnd_resolver`

## Requirements
- R1: Instruction fields: source mode is bits 5:4, source register bits 11:8, destination register bits 3:0, destination indirect bit 7, byte operation bit 6. When bits 15:10 equal 000100 the instruction is single-operand. Its operand register is then bits 3:0, it follows the source rules, `single_op` is 1 and the destination kind is NONE. Kind encoding on `src_kind`/`dst_kind`: 0 REG, 1 MEM, 2 CONST, 3 NONE.
- R2: For a general register (R1, R4..R15) in source mode 0, the result is kind REG with `src_reg` equal to that register.
- R3: For a general register in source mode 1, the result is MEM at the register value plus the extension word. In mode 2 it is MEM at the register value.
- R4: For a general register in source mode 3, the result is MEM at the register value. That register is then written with its value plus 1 for byte operations or plus 2 for word operations.
- R5: With R0 as source, mode 1 gives MEM at (address of the extension word + extension word). Mode 3 gives CONST equal to the extension word.
- R6: With R2 as source, mode 0 gives REG 2 and mode 1 gives MEM at the extension word. Modes 2 and 3 give CONST 4 and CONST 8.
- R7: With R3 as source, modes 0, 1, 2 and 3 give CONST 0x0000, 0x0001, 0x0002 and 0xFFFF. No memory read is made and the program counter is not advanced.
- R8: Each extension word consumed advances the program counter by 2. `pc_wdata` equals the address just read plus 2. The source word is consumed before the destination word.
- R9: Destination bit 7 = 0 gives REG. If bit 6 is also 1, the destination register is rewritten with its upper byte cleared. With bit 7 = 1 the destination is MEM: relative to the extension word's address for R0, absolute for R2, and register plus extension word otherwise. No upper-byte clear happens then.
- R10: `mem_rd` lasts one cycle and its data is used the following cycle. `done` is a one-cycle pulse issued once all operand outputs are valid. After reset `done`, `mem_rd`, `pc_we` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load instruction and begin resolution (sampled when idle) |
| instr | input | 16 | Instruction word |
| pc_i | input | 16 | Program counter pointing at the word after the opcode |
| rf_rsel | output | 4 | Register file read select |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register write enable (auto-increment or byte clear) |
| rf_wsel | output | 4 | Register write select |
| rf_wdata | output | 16 | Register write data |
| pc_we | output | 1 | Program counter write enable |
| pc_wdata | output | 16 | New program counter value |
| mem_rd | output | 1 | Memory read request for an extension word |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle pulse: operand outputs valid |
| single_op | output | 1 | Instruction is single-operand |
| src_kind | output | 2 | Source operand kind |
| src_reg | output | 4 | Source register select (kind REG) |
| src_addr | output | 16 | Source effective address (kind MEM) |
| src_val | output | 16 | Source literal (kind CONST) |
| dst_kind | output | 2 | Destination operand kind |
| dst_reg | output | 4 | Destination register select (kind REG) |
| dst_addr | output | 16 | Destination effective address (kind MEM) |

## Verification
The hardest case to reach is an instruction that consumes two extension words and also has a relative destination. The destination base must then be the program counter after the source word has already advanced it, so a design that latched the counter at start would still pass every single-word case. The stimulus covers this with an immediate source and an R0-relative destination, and with indexed forms on both operands. In both cases the two words carry different values, so that swapping their order changes the results. Writes to other registers are checked at the register file model after each `done`. Examples are auto-increment, the byte-destination clear, and the non-clearing byte forms.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int unsigned WORD_W    = 16;
    localparam int unsigned REG_SEL_W = 4;
    localparam int unsigned MODE_W    = 2;
    localparam int unsigned PC_STEP   = 2;
    localparam int unsigned OPC_W     = 6;

    localparam logic [OPC_W-1:0]     SINGLE_OPC = 6'b000100;
    localparam logic [REG_SEL_W-1:0] REG_PC     = 4'd0;
    localparam logic [REG_SEL_W-1:0] REG_CG1    = 4'd2;
    localparam logic [REG_SEL_W-1:0] REG_CG2    = 4'd3;
    localparam logic [WORD_W-1:0]    LOW_MASK   = 16'h00FF;

    typedef enum logic [1:0] {
        OPK_REG   = 2'd0,
        OPK_MEM   = 2'd1,
        OPK_CONST = 2'd2,
        OPK_NONE  = 2'd3
    } opnd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SRC     = 3'd1,
        ST_SRC_EXT = 3'd2,
        ST_DST     = 3'd3,
        ST_DST_EXT = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [MODE_W-1:0]    s_mode;
        logic [REG_SEL_W-1:0] s_reg;
        logic [REG_SEL_W-1:0] d_reg;
        logic                 d_ind;
        logic                 byte_op;
        logic                 single;
    } insn_fields_t;

    typedef struct packed {
        opnd_kind_e           kind;
        logic [REG_SEL_W-1:0] sel;
        logic [WORD_W-1:0]    addr;
        logic [WORD_W-1:0]    value;
    } opnd_res_t;

    function automatic insn_fields_t split_insn(input logic [WORD_W-1:0] w);
        insn_fields_t f;
        f.single  = (w[15:10] == SINGLE_OPC);
        f.s_mode  = w[5:4];
        f.s_reg   = f.single ? w[3:0] : w[11:8];
        f.d_reg   = w[3:0];
        f.d_ind   = w[7];
        f.byte_op = w[6];
        return f;
    endfunction

    // Literal produced by the constant-generator registers.
    function automatic logic [WORD_W-1:0] gen_const(input logic [REG_SEL_W-1:0] r,
                                                    input logic [MODE_W-1:0]    m);
        logic [WORD_W-1:0] v;
        if (r == REG_CG2) begin
            v = (m == 2'd3) ? {WORD_W{1'b1}} : {{(WORD_W-MODE_W){1'b0}}, m};
        end else begin
            v = m[0] ? WORD_W'(8) : WORD_W'(4);
        end
        return v;
    endfunction

    function automatic opnd_res_t res_none();
        opnd_res_t r;
        r.kind  = OPK_NONE;
        r.sel   = '0;
        r.addr  = '0;
        r.value = '0;
        return r;
    endfunction

endpackage

// File: rtl/opnd_src_map.sv
module opnd_src_map
    import opnd_pkg::*;
(
    input  logic [MODE_W-1:0]    mode,
    input  logic [REG_SEL_W-1:0] rsel,
    input  logic                 byte_op,
    input  logic [WORD_W-1:0]    rval,
    input  logic [WORD_W-1:0]    pc,
    input  logic [WORD_W-1:0]    ext,
    output logic                 needs_ext,
    output opnd_res_t            res,
    output logic                 postinc,
    output logic [WORD_W-1:0]    inc_val
);

    localparam logic [WORD_W-1:0] STEP_B = WORD_W'(1);
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(2);

    always_comb begin
        needs_ext = 1'b0;
        postinc   = 1'b0;
        inc_val   = rval + (byte_op ? STEP_B : STEP_W);
        res       = res_none();
        res.sel   = rsel;
        if (rsel == REG_CG2) begin
            res.kind  = OPK_CONST;
            res.value = gen_const(rsel, mode);
        end else if (rsel == REG_CG1) begin
            case (mode)
                2'd0: res.kind = OPK_REG;
                2'd1: begin
                    needs_ext = 1'b1;
                    res.kind  = OPK_MEM;
                    res.addr  = ext;
                end
                default: begin
                    res.kind  = OPK_CONST;
                    res.value = gen_const(rsel, mode);
                end
            endcase
        end else if (rsel == REG_PC) begin
            case (mode)
                2'd0: res.kind = OPK_REG;
                2'd1: begin
                    needs_ext = 1'b1;
                    res.kind  = OPK_MEM;
                    res.addr  = pc + ext;
                end
                2'd2: begin
                    res.kind = OPK_MEM;
                    res.addr = pc;
                end
                default: begin
                    needs_ext = 1'b1;
                    res.kind  = OPK_CONST;
                    res.value = ext;
                end
            endcase
        end else begin
            case (mode)
                2'd0: res.kind = OPK_REG;
                2'd1: begin
                    needs_ext = 1'b1;
                    res.kind  = OPK_MEM;
                    res.addr  = rval + ext;
                end
                2'd2: begin
                    res.kind = OPK_MEM;
                    res.addr = rval;
                end
                default: begin
                    res.kind = OPK_MEM;
                    res.addr = rval;
                    postinc  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/opnd_dst_map.sv
module opnd_dst_map
    import opnd_pkg::*;
(
    input  logic                 ind,
    input  logic [REG_SEL_W-1:0] rsel,
    input  logic [WORD_W-1:0]    rval,
    input  logic [WORD_W-1:0]    pc,
    input  logic [WORD_W-1:0]    ext,
    output logic                 needs_ext,
    output opnd_res_t            res
);

    always_comb begin
        res       = res_none();
        res.sel   = rsel;
        needs_ext = ind;
        if (!ind) begin
            res.kind = OPK_REG;
        end else begin
            res.kind = OPK_MEM;
            if (rsel == REG_PC) begin
                res.addr = pc + ext;
            end else if (rsel == REG_CG1) begin
                res.addr = ext;
            end else begin
                res.addr = rval + ext;
            end
        end
    end

endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
    import opnd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       src_ext,
    input  logic       dst_ext,
    output seq_state_e state
);

    seq_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    nxt = start ? ST_SRC : ST_IDLE;
            ST_SRC:     nxt = src_ext ? ST_SRC_EXT : ST_DST;
            ST_SRC_EXT: nxt = ST_DST;
            ST_DST:     nxt = dst_ext ? ST_DST_EXT : ST_DONE;
            ST_DST_EXT: nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
    import opnd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [WORD_W-1:0]    instr,
    input  logic [WORD_W-1:0]    pc_i,
    output logic [REG_SEL_W-1:0] rf_rsel,
    input  logic [WORD_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [REG_SEL_W-1:0] rf_wsel,
    output logic [WORD_W-1:0]    rf_wdata,
    output logic                 pc_we,
    output logic [WORD_W-1:0]    pc_wdata,
    output logic                 mem_rd,
    output logic [WORD_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 done,
    output logic                 single_op,
    output logic [1:0]           src_kind,
    output logic [REG_SEL_W-1:0] src_reg,
    output logic [WORD_W-1:0]    src_addr,
    output logic [WORD_W-1:0]    src_val,
    output logic [1:0]           dst_kind,
    output logic [REG_SEL_W-1:0] dst_reg,
    output logic [WORD_W-1:0]    dst_addr
);

    seq_state_e        st;
    insn_fields_t      f_q;
    logic [WORD_W-1:0] pc_q;
    opnd_res_t         src_q;
    opnd_res_t         dst_q;

    logic              s_need;
    logic              s_postinc;
    logic [WORD_W-1:0] s_inc;
    opnd_res_t         s_res;
    logic              d_need;
    logic              d_need_eff;
    opnd_res_t         d_res;
    logic              in_dst;

    assign d_need_eff = d_need & ~f_q.single;
    assign in_dst     = (st == ST_DST) || (st == ST_DST_EXT);
    assign rf_rsel    = in_dst ? f_q.d_reg : f_q.s_reg;

    opnd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .src_ext (s_need),
        .dst_ext (d_need_eff),
        .state   (st)
    );

    opnd_src_map u_src (
        .mode      (f_q.s_mode),
        .rsel      (f_q.s_reg),
        .byte_op   (f_q.byte_op),
        .rval      (rf_rdata),
        .pc        (pc_q),
        .ext       (mem_rdata),
        .needs_ext (s_need),
        .res       (s_res),
        .postinc   (s_postinc),
        .inc_val   (s_inc)
    );

    opnd_dst_map u_dst (
        .ind       (f_q.d_ind),
        .rsel      (f_q.d_reg),
        .rval      (rf_rdata),
        .pc        (pc_q),
        .ext       (mem_rdata),
        .needs_ext (d_need),
        .res       (d_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q   <= '0;
            pc_q  <= '0;
            src_q <= res_none();
            dst_q <= res_none();
        end else begin
            if (st == ST_IDLE && start) begin
                f_q  <= split_insn(instr);
                pc_q <= pc_i;
            end
            if ((st == ST_SRC && !s_need) || st == ST_SRC_EXT) begin
                src_q <= s_res;
            end
            if (st == ST_SRC_EXT || st == ST_DST_EXT) begin
                pc_q <= pc_q + WORD_W'(PC_STEP);
            end
            if (st == ST_DST && !d_need_eff) begin
                dst_q <= f_q.single ? res_none() : d_res;
            end
            if (st == ST_DST_EXT) begin
                dst_q <= d_res;
            end
        end
    end

    always_comb begin
        rf_we    = 1'b0;
        rf_wsel  = f_q.s_reg;
        rf_wdata = s_inc;
        if (st == ST_SRC && s_postinc) begin
            rf_we = 1'b1;
        end else if (st == ST_DST && !f_q.single && !f_q.d_ind && f_q.byte_op) begin
            rf_we    = 1'b1;
            rf_wsel  = f_q.d_reg;
            rf_wdata = rf_rdata & LOW_MASK;
        end
    end

    assign mem_rd   = (st == ST_SRC && s_need) || (st == ST_DST && d_need_eff);
    assign mem_addr = pc_q;
    assign pc_we    = (st == ST_SRC_EXT) || (st == ST_DST_EXT);
    assign pc_wdata = pc_q + WORD_W'(PC_STEP);
    assign done     = (st == ST_DONE);

    assign single_op = f_q.single;
    assign src_kind  = src_q.kind;
    assign src_reg   = src_q.sel;
    assign src_addr  = src_q.addr;
    assign src_val   = src_q.value;
    assign dst_kind  = dst_q.kind;
    assign dst_reg   = dst_q.sel;
    assign dst_addr  = dst_q.addr;

endmodule

// File: rtl/opnd_resolver_chk.sv
module opnd_resolver_chk
    import opnd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              mem_rd,
    input logic [WORD_W-1:0] mem_addr,
    input logic              pc_we,
    input logic [WORD_W-1:0] pc_wdata,
    input logic              rf_we,
    input logic              single_op,
    input logic [1:0]        dst_kind
);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_read_single_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_pc_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> ($past(mem_rd) && pc_wdata == $past(mem_addr) + WORD_W'(PC_STEP)));

    assert_single_no_dst_R1: assert property (@(posedge clk) disable iff (rst)
        (done && single_op) |-> dst_kind == OPK_NONE);

    assert_write_ports_apart_R9: assert property (@(posedge clk) disable iff (rst)
        !(rf_we && pc_we));

endmodule

bind opnd_resolver opnd_resolver_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .pc_we     (pc_we),
    .pc_wdata  (pc_wdata),
    .rf_we     (rf_we),
    .single_op (single_op),
    .dst_kind  (dst_kind)
);

// File: tb/opnd_resolver_tb_top.sv
`timescale 1ns/1ps
module opnd_resolver_tb_top;

    localparam logic [15:0] PC0 = 16'h0040;
    localparam int K_REG = 0, K_MEM = 1, K_CONST = 2, K_NONE = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_i = PC0;
    logic [3:0]  rf_rsel;
    logic [15:0] rf_rdata;
    logic        rf_we;
    logic [3:0]  rf_wsel;
    logic [15:0] rf_wdata;
    logic        pc_we;
    logic [15:0] pc_wdata;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        done;
    logic        single_op;
    logic [1:0]  src_kind;
    logic [3:0]  src_reg;
    logic [15:0] src_addr;
    logic [15:0] src_val;
    logic [1:0]  dst_kind;
    logic [3:0]  dst_reg;
    logic [15:0] dst_addr;

    logic [15:0] regs [16];
    logic [15:0] mem  [128];

    int tests = 0;
    int fails = 0;

    typedef struct {
        string       tag;
        int          sk;
        logic [3:0]  sr;
        logic [15:0] sa;
        logic [15:0] sv;
        int          dk;
        logic [3:0]  dr;
        logic [15:0] da;
        logic [15:0] pc;
        int          ca;
        logic [15:0] cav;
        int          cb;
        logic [15:0] cbv;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    opnd_resolver dut_i (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_i(pc_i),
        .rf_rsel(rf_rsel), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wsel(rf_wsel),
        .rf_wdata(rf_wdata), .pc_we(pc_we), .pc_wdata(pc_wdata), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .done(done), .single_op(single_op),
        .src_kind(src_kind), .src_reg(src_reg), .src_addr(src_addr), .src_val(src_val),
        .dst_kind(dst_kind), .dst_reg(dst_reg), .dst_addr(dst_addr)
    );

    assign rf_rdata = regs[rf_rsel];

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:1]];
        if (rf_we) regs[rf_wsel] <= rf_wdata;
        if (pc_we) regs[0] <= pc_wdata;
    end

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop expected item when the design signals completion.
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                check("R10", "unexpected done", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "src_kind", 16'(src_kind), 16'(e.sk));
                if (e.sk == K_REG)   check(e.tag, "src_reg",  16'(src_reg), 16'(e.sr));
                if (e.sk == K_MEM)   check(e.tag, "src_addr", src_addr, e.sa);
                if (e.sk == K_CONST) check(e.tag, "src_val",  src_val, e.sv);
                check(e.tag, "dst_kind", 16'(dst_kind), 16'(e.dk));
                if (e.dk == K_REG) check(e.tag, "dst_reg",  16'(dst_reg), 16'(e.dr));
                if (e.dk == K_MEM) check(e.tag, "dst_addr", dst_addr, e.da);
                check(e.tag, "single_op", 16'(single_op), 16'(e.dk == K_NONE));
                check(e.tag, "pc", regs[0], e.pc);
                check(e.tag, "reg a", regs[e.ca], e.cav);
                check(e.tag, "reg b", regs[e.cb], e.cbv);
            end
        end
    end

    function automatic logic [15:0] rinit(input int i);
        return (i == 0) ? PC0 : 16'h1000 + 16'(i * 16);
    endfunction

    // Driver: sets up state, queues the expectation, starts, waits for result.
    task automatic run(input string tag, input logic [15:0] w,
                       input logic [15:0] e1, input logic [15:0] e2,
                       input int sk, input logic [3:0] sr, input logic [15:0] sa,
                       input logic [15:0] sv, input int dk, input logic [3:0] dr,
                       input logic [15:0] da, input logic [15:0] pc,
                       input int ca, input logic [15:0] cav,
                       input int cb, input logic [15:0] cbv);
        exp_t e;
        @(negedge clk);
        for (int i = 0; i < 16; i++) regs[i] = rinit(i);
        mem[PC0[7:1]]      = e1;
        mem[PC0[7:1] + 1]  = e2;
        e.tag = tag; e.sk = sk; e.sr = sr; e.sa = sa; e.sv = sv;
        e.dk = dk; e.dr = dr; e.da = da; e.pc = pc;
        e.ca = ca; e.cav = cav; e.cb = cb; e.cbv = cbv;
        q.push_back(e);
        instr = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 50 && q.size() != 0; n++) @(negedge clk);
        if (q.size() != 0) begin
            check(tag, "no done", 16'd0, 16'd1);
            q.delete();
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        for (int i = 0; i < 16; i++) regs[i] = rinit(i);
        repeat (3) @(negedge clk);
        check("R10", "reset done",   16'(done), 16'd0);
        check("R10", "reset mem_rd", 16'(mem_rd), 16'd0);
        check("R10", "reset pc_we",  16'(pc_we), 16'd0);
        check("R10", "reset rf_we",  16'(rf_we), 16'd0);
        rst = 1'b0;
        // R2: register source and register destination
        run("R2", 16'h4506, 0, 0, K_REG, 5, 0, 0, K_REG, 6, 0, PC0, 5, 16'h1050, 6, 16'h1060);
        // R3: indexed and indirect
        run("R3", 16'h4516, 16'h0004, 0, K_MEM, 0, 16'h1054, 0, K_REG, 6, 0, PC0 + 2, 5, 16'h1050, 15, 16'h10F0);
        run("R3", 16'h4726, 0, 0, K_MEM, 0, 16'h1070, 0, K_REG, 6, 0, PC0, 7, 16'h1070, 15, 16'h10F0);
        // R4: auto-increment byte (+1, with dst clear R9) and word (+2)
        run("R4", 16'h4776, 0, 0, K_MEM, 0, 16'h1070, 0, K_REG, 6, 0, PC0, 7, 16'h1071, 6, 16'h0060);
        run("R4", 16'h4738, 0, 0, K_MEM, 0, 16'h1070, 0, K_REG, 8, 0, PC0, 7, 16'h1072, 8, 16'h1080);
        // R5: relative and immediate
        run("R5", 16'h4016, 16'h0100, 0, K_MEM, 0, 16'h0140, 0, K_REG, 6, 0, PC0 + 2, 15, 16'h10F0, 6, 16'h1060);
        run("R5", 16'h4036, 16'hBEEF, 0, K_CONST, 0, 0, 16'hBEEF, K_REG, 6, 0, PC0 + 2, 15, 16'h10F0, 6, 16'h1060);
        // R6: R2 modes
        run("R6", 16'h4216, 16'h0200, 0, K_MEM, 0, 16'h0200, 0, K_REG, 6, 0, PC0 + 2, 2, 16'h1020, 15, 16'h10F0);
        run("R6", 16'h4206, 0, 0, K_REG, 2, 0, 0, K_REG, 6, 0, PC0, 2, 16'h1020, 15, 16'h10F0);
        run("R6", 16'h4226, 0, 0, K_CONST, 0, 0, 16'h0004, K_REG, 6, 0, PC0, 2, 16'h1020, 15, 16'h10F0);
        run("R6", 16'h4236, 0, 0, K_CONST, 0, 0, 16'h0008, K_REG, 6, 0, PC0, 2, 16'h1020, 15, 16'h10F0);
        // R7: R3 constants, no PC advance
        run("R7", 16'h4306, 16'h5555, 0, K_CONST, 0, 0, 16'h0000, K_REG, 6, 0, PC0, 3, 16'h1030, 15, 16'h10F0);
        run("R7", 16'h4316, 16'h5555, 0, K_CONST, 0, 0, 16'h0001, K_REG, 6, 0, PC0, 3, 16'h1030, 15, 16'h10F0);
        run("R7", 16'h4326, 16'h5555, 0, K_CONST, 0, 0, 16'h0002, K_REG, 6, 0, PC0, 3, 16'h1030, 15, 16'h10F0);
        run("R7", 16'h4336, 16'h5555, 0, K_CONST, 0, 0, 16'hFFFF, K_REG, 6, 0, PC0, 3, 16'h1030, 15, 16'h10F0);
        // R9: destination memory forms and byte behaviour
        run("R9", 16'h4580, 16'h0010, 0, K_REG, 5, 0, 0, K_MEM, 0, 16'h0050, PC0 + 2, 15, 16'h10F0, 5, 16'h1050);
        run("R9", 16'h4582, 16'h0300, 0, K_REG, 5, 0, 0, K_MEM, 0, 16'h0300, PC0 + 2, 2, 16'h1020, 15, 16'h10F0);
        run("R9", 16'h4589, 16'h0006, 0, K_REG, 5, 0, 0, K_MEM, 0, 16'h1096, PC0 + 2, 9, 16'h1090, 15, 16'h10F0);
        run("R9", 16'h4546, 0, 0, K_REG, 5, 0, 0, K_REG, 6, 0, PC0, 6, 16'h0060, 5, 16'h1050);
        run("R9", 16'h45C9, 16'h0006, 0, K_REG, 5, 0, 0, K_MEM, 0, 16'h1096, PC0 + 2, 9, 16'h1090, 5, 16'h1050);
        // R8: two extension words, source first
        run("R8", 16'h4599, 16'h0004, 16'h0008, K_MEM, 0, 16'h1054, 0, K_MEM, 0, 16'h1098, PC0 + 4, 5, 16'h1050, 9, 16'h1090);
        run("R8", 16'h40B0, 16'h1234, 16'h0020, K_CONST, 0, 0, 16'h1234, K_MEM, 0, 16'h0062, PC0 + 4, 15, 16'h10F0, 6, 16'h1060);
        // R1: single-operand forms
        run("R1", 16'h1005, 0, 0, K_REG, 5, 0, 0, K_NONE, 0, 0, PC0, 5, 16'h1050, 15, 16'h10F0);
        run("R1", 16'h1036, 0, 0, K_MEM, 0, 16'h1060, 0, K_NONE, 0, 0, PC0, 6, 16'h1062, 15, 16'h10F0);
        run("R1", 16'h1015, 16'h0002, 0, K_MEM, 0, 16'h1052, 0, K_NONE, 0, 0, PC0 + 2, 5, 16'h1050, 15, 16'h10F0);
        run("R1", 16'h1045, 0, 0, K_REG, 5, 0, 0, K_NONE, 0, 0, PC0, 5, 16'h1050, 15, 16'h10F0);
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule